// File: doc/BRIEF.md
# Scalar Q15 Saturating ALU

This execution unit sits beside the integer datapath of a 32-bit core. It carries out seven scalar fixed-point operations: signed add and subtract, unsigned add and subtract, and three Q15 fractional multiplies. Every result is clamped into a 16-bit range and then returned as a full register-width word. The function field of the instruction picks the operation. Whenever a clamp takes place, the unit pulses a flag that the core uses to set its sticky saturation status bit.

Operands arrive with the function code on a valid/ready input stream. The result, the saturation pulse and an illegal-function indication leave on a valid/ready output stream one clock later. The result is held in a single output register:

- The unit accepts a new operation whenever that register is empty or is being drained in the same cycle, so `in_ready` is `!out_valid || out_ready`.
- While `out_valid` is high and `out_ready` is low, the output register and all of its fields stay frozen.
- While the unit is stalled in this way, `in_ready` is low.

Top module: `q15_sat_alu`

## Requirements
- R1: `in_func` decodes as follows: 7'b0000010 signed add, 7'b0000011 signed subtract, 7'b0001010 unsigned add, 7'b0001011 unsigned subtract, 7'b0000110 bottom-by-bottom multiply, 7'b0001110 bottom-by-top multiply, 7'b0010110 top-by-top multiply.
- R2: Signed add treats bits 31:0 of each operand as signed and forms the exact sum. It clamps the sum to -32768..32767.
- R3: Signed subtract forms the exact difference a - b of the signed low words and clamps it to -32768..32767.
- R4: Unsigned add treats the low words as unsigned and saturates the sum to 32 bits. It then clamps the value to 0..65535. The returned word is sign-extended from bit 15, so 65535 reads as all ones.
- R5: Unsigned subtract returns 0 when a < b (as unsigned low words) and flags saturation. Otherwise it returns a - b clamped to 0..65535, sign-extended from bit 15.
- R6: The fractional multiplies form the signed product of two halfwords and shift it arithmetically right by 15. Halfwords are chosen as follows: bottom-by-bottom uses a[15:0] and b[15:0]; bottom-by-top uses a[15:0] and b[31:16]; top-by-top uses a[31:16] and b[31:16].
- R7: A fractional multiply of 16'h8000 by 16'h8000 returns 32767 with the saturation flag set. Every other halfword pair returns without saturation.
- R8: `out_sat` is high with a result exactly when that result was clamped. It is never high while `out_valid` is low.
- R9: Any other `in_func` value gives a zero result, `out_sat` low and `out_illegal` high.
- R10: An operation accepted on an edge (`in_valid && in_ready`) is presented with `out_valid` high right after that edge. `in_ready` equals `!out_valid || out_ready`.
- R11: While `out_valid` is high and `out_ready` is low, `out_result`, `out_sat` and `out_illegal` hold, and `out_valid` stays high.
- R12: During reset `out_valid` is low and `in_ready` is high.
- R13: Signed results are sign-extended from bit 15 over the full register width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_func | input | 7 | Function selector |
| in_a | input | XLEN | First source operand |
| in_b | input | XLEN | Second source operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | XLEN | Clamped, sign-extended result |
| out_sat | output | 1 | Saturation flag update, qualified by out_valid |
| out_illegal | output | 1 | Function code not recognised, qualified by out_valid |

## Verification
The assertions check the stream rules on every cycle:
- the one-cycle latency and the ready equation;
- the freeze of the output fields during back-pressure;
- the flag being qualified by valid;
- the zero, unflagged result of an illegal code;
- sign extension of every result;
- the floor of unsigned subtract;
- the 32767 result of the lone multiply overflow.

Only the bench scenarios can show that every arithmetic value is correct. They compare random and directed operands against an independent model of all seven operations, and exercise halfword selection, two-stage unsigned clamping and stall-then-release sequencing.

// File: rtl/q15_pkg.sv
package q15_pkg;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_SADD = 3'd1,
    OP_SSUB = 3'd2,
    OP_UADD = 3'd3,
    OP_USUB = 3'd4,
    OP_MBB  = 3'd5,
    OP_MBT  = 3'd6,
    OP_MTT  = 3'd7
  } q15_op_e;

  localparam int FUNCW = 7;

  localparam logic [FUNCW-1:0] FN_SADD = 7'b0000010;
  localparam logic [FUNCW-1:0] FN_SSUB = 7'b0000011;
  localparam logic [FUNCW-1:0] FN_UADD = 7'b0001010;
  localparam logic [FUNCW-1:0] FN_USUB = 7'b0001011;
  localparam logic [FUNCW-1:0] FN_MBB  = 7'b0000110;
  localparam logic [FUNCW-1:0] FN_MBT  = 7'b0001110;
  localparam logic [FUNCW-1:0] FN_MTT  = 7'b0010110;

  typedef struct packed {
    q15_op_e op;
    logic    is_mul;
    logic    legal;
  } q15_dec_t;

endpackage

// File: rtl/q15_decode.sv
module q15_decode
  import q15_pkg::*;
(
  input  logic [FUNCW-1:0] func,
  output q15_dec_t         dec
);

  always_comb begin
    dec.op     = OP_NONE;
    dec.is_mul = 1'b0;
    dec.legal  = 1'b1;
    unique case (func)
      FN_SADD: dec.op = OP_SADD;
      FN_SSUB: dec.op = OP_SSUB;
      FN_UADD: dec.op = OP_UADD;
      FN_USUB: dec.op = OP_USUB;
      FN_MBB: begin
        dec.op     = OP_MBB;
        dec.is_mul = 1'b1;
      end
      FN_MBT: begin
        dec.op     = OP_MBT;
        dec.is_mul = 1'b1;
      end
      FN_MTT: begin
        dec.op     = OP_MTT;
        dec.is_mul = 1'b1;
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/q15_addsub.sv
module q15_addsub
  import q15_pkg::*;
#(
  parameter int OPW = 32,
  parameter int RW  = 16
) (
  input  q15_op_e         op,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  output logic [RW-1:0]   res,
  output logic            sat
);

  localparam int SW = OPW + 2;
  localparam logic signed [SW-1:0] SMAX   = SW'((64'd1 << (RW-1)) - 64'd1);
  localparam logic signed [SW-1:0] SMIN   = -SMAX - SW'(1);
  localparam logic [OPW-1:0]       UMAXR  = OPW'((64'd1 << RW) - 64'd1);
  localparam logic [OPW-1:0]       UMAXW  = '1;

  logic signed [SW-1:0] s_val;
  logic [OPW:0]         u_sum;
  logic [OPW:0]         u_dif;
  logic [OPW-1:0]       u_wide;
  logic                 u_sat_wide;

  // Signed path: exact at two bits of headroom, then clamp to RW bits.
  always_comb begin
    if (op == OP_SSUB)
      s_val = $signed({{2{a[OPW-1]}}, a}) - $signed({{2{b[OPW-1]}}, b});
    else
      s_val = $signed({{2{a[OPW-1]}}, a}) + $signed({{2{b[OPW-1]}}, b});
  end

  // Unsigned path: first clamp to OPW bits, then to RW bits.
  assign u_sum = {1'b0, a} + {1'b0, b};
  assign u_dif = {1'b0, a} - {1'b0, b};

  always_comb begin
    if (op == OP_USUB) begin
      u_sat_wide = u_dif[OPW];
      u_wide     = u_dif[OPW] ? '0 : u_dif[OPW-1:0];
    end else begin
      u_sat_wide = u_sum[OPW];
      u_wide     = u_sum[OPW] ? UMAXW : u_sum[OPW-1:0];
    end
  end

  always_comb begin
    res = '0;
    sat = 1'b0;
    if (op == OP_UADD || op == OP_USUB) begin
      if (u_wide > UMAXR) begin
        res = UMAXR[RW-1:0];
        sat = 1'b1;
      end else begin
        res = u_wide[RW-1:0];
        sat = u_sat_wide;
      end
    end else if (op == OP_SADD || op == OP_SSUB) begin
      if (s_val > SMAX) begin
        res = SMAX[RW-1:0];
        sat = 1'b1;
      end else if (s_val < SMIN) begin
        res = SMIN[RW-1:0];
        sat = 1'b1;
      end else begin
        res = s_val[RW-1:0];
      end
    end
  end

endmodule

// File: rtl/q15_frac_mul.sv
module q15_frac_mul
  import q15_pkg::*;
#(
  parameter int OPW = 32,
  parameter int HW  = 16
) (
  input  q15_op_e         op,
  input  logic [OPW-1:0]  a,
  input  logic [OPW-1:0]  b,
  output logic [HW-1:0]   res,
  output logic            sat
);

  localparam int PW = 2 * HW;
  localparam logic signed [PW-1:0] MMAX = PW'((64'd1 << (HW-1)) - 64'd1);
  localparam logic signed [PW-1:0] MMIN = -MMAX - PW'(1);

  logic signed [HW-1:0] a_h;
  logic signed [HW-1:0] b_h;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shifted;

  // Halfword pick: first operand goes high only for top-by-top,
  // second operand stays low only for bottom-by-bottom.
  assign a_h = (op == OP_MTT) ? a[2*HW-1:HW] : a[HW-1:0];
  assign b_h = (op == OP_MBB) ? b[HW-1:0]    : b[2*HW-1:HW];

  assign prod    = a_h * b_h;
  assign shifted = prod >>> (HW - 1);

  always_comb begin
    if (shifted > MMAX) begin
      res = MMAX[HW-1:0];
      sat = 1'b1;
    end else if (shifted < MMIN) begin
      res = MMIN[HW-1:0];
      sat = 1'b1;
    end else begin
      res = shifted[HW-1:0];
      sat = 1'b0;
    end
  end

endmodule

// File: rtl/q15_out_stage.sv
module q15_out_stage #(
  parameter int XLEN = 32,
  parameter int RW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [RW-1:0]   res,
  input  logic            sat,
  input  logic            ill,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_sat,
  output logic            out_illegal
);

  logic [XLEN-1:0] ext;

  generate
    if (XLEN > RW) begin : g_sext
      assign ext = {{(XLEN-RW){res[RW-1]}}, res};
    end else begin : g_trunc
      assign ext = res[XLEN-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_sat     <= 1'b0;
      out_illegal <= 1'b0;
    end else if (take) begin
      out_valid   <= 1'b1;
      out_result  <= ext;
      out_sat     <= sat;
      out_illegal <= ill;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
      out_sat     <= 1'b0;
      out_illegal <= 1'b0;
    end
  end

  // R13 / R4: result upper bits always replicate bit RW-1
  generate
    if (XLEN > RW) begin : g_sext_chk
      p_sext_r13: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result[XLEN-1:RW] == {(XLEN-RW){out_result[RW-1]}}));
    end
  endgenerate

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)
                                   && $stable(out_sat) && $stable(out_illegal)));

  p_flag_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sat || out_illegal) |-> out_valid);

endmodule

// File: rtl/q15_sat_alu.sv
module q15_sat_alu
  import q15_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [6:0]       in_func,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic             out_sat,
  output logic             out_illegal
);

  localparam int OPW = 32;
  localparam int RW  = 16;

  q15_dec_t        dec;
  logic [OPW-1:0]  a_w;
  logic [OPW-1:0]  b_w;
  logic [RW-1:0]   as_res;
  logic            as_sat;
  logic [RW-1:0]   mu_res;
  logic            mu_sat;
  logic [RW-1:0]   sel_res;
  logic            sel_sat;
  logic            take;

  assign a_w = in_a[OPW-1:0];
  assign b_w = in_b[OPW-1:0];

  q15_decode i_dec (
    .func (in_func),
    .dec  (dec)
  );

  q15_addsub #(.OPW(OPW), .RW(RW)) i_addsub (
    .op  (dec.op),
    .a   (a_w),
    .b   (b_w),
    .res (as_res),
    .sat (as_sat)
  );

  q15_frac_mul #(.OPW(OPW), .HW(RW)) i_mul (
    .op  (dec.op),
    .a   (a_w),
    .b   (b_w),
    .res (mu_res),
    .sat (mu_sat)
  );

  always_comb begin
    if (!dec.legal) begin
      sel_res = '0;
      sel_sat = 1'b0;
    end else if (dec.is_mul) begin
      sel_res = mu_res;
      sel_sat = mu_sat;
    end else begin
      sel_res = as_res;
      sel_sat = as_sat;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  q15_out_stage #(.XLEN(XLEN), .RW(RW)) i_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .take        (take),
    .res         (sel_res),
    .sat         (sel_sat),
    .ill         (!dec.legal),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_sat     (out_sat),
    .out_illegal (out_illegal)
  );

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_illegal_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_result == '0 && !out_sat));

  p_mul_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec.is_mul && mu_sat) |=> (out_result[RW-1:0] == 16'h7fff && out_sat));

  p_usub_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_func == FN_USUB && a_w < b_w) |=> (out_result == '0 && out_sat));

endmodule

// File: tb/test_q15_sat_alu.sv
module test_q15_sat_alu;

  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [6:0]      in_func = '0;
  logic [XLEN-1:0] in_a = '0;
  logic [XLEN-1:0] in_b = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [XLEN-1:0] out_result;
  logic            out_sat;
  logic            out_illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  q15_sat_alu #(.XLEN(XLEN)) i_q15_sat_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_sat(out_sat),
    .out_illegal(out_illegal)
  );

  function automatic logic [31:0] sx16(input longint v);
    logic [15:0] t;
    t = v[15:0];
    return {{16{t[15]}}, t};
  endfunction

  function automatic void model(input logic [6:0] f, input logic [31:0] a,
                                input logic [31:0] b, output logic [31:0] r,
                                output bit s, output bit ill);
    longint v;
    longint ha;
    longint hb;
    s = 1'b0; ill = 1'b0; r = '0;
    case (f)
      7'b0000010, 7'b0000011: begin
        if (f == 7'b0000010) v = longint'($signed(a)) + longint'($signed(b));
        else                 v = longint'($signed(a)) - longint'($signed(b));
        if (v > 32767)  begin v = 32767;  s = 1'b1; end
        if (v < -32768) begin v = -32768; s = 1'b1; end
        r = sx16(v);
      end
      7'b0001010, 7'b0001011: begin
        if (f == 7'b0001010) begin
          v = longint'(a) + longint'(b);
          if (v > 64'hFFFFFFFF) begin v = 64'hFFFFFFFF; s = 1'b1; end
        end else begin
          if (a < b) begin v = 0; s = 1'b1; end
          else v = longint'(a) - longint'(b);
        end
        if (v > 65535) begin v = 65535; s = 1'b1; end
        r = sx16(v);
      end
      7'b0000110, 7'b0001110, 7'b0010110: begin
        ha = (f == 7'b0010110) ? longint'($signed(a[31:16])) : longint'($signed(a[15:0]));
        hb = (f == 7'b0000110) ? longint'($signed(b[15:0]))  : longint'($signed(b[31:16]));
        v = (ha * hb) >>> 15;
        if (v > 32767)  begin v = 32767;  s = 1'b1; end
        if (v < -32768) begin v = -32768; s = 1'b1; end
        r = sx16(v);
      end
      default: ill = 1'b1;
    endcase
  endfunction

  function automatic string tag_of(input logic [6:0] f);
    case (f)
      7'b0000010: return "R2";
      7'b0000011: return "R3";
      7'b0001010: return "R4";
      7'b0001011: return "R5";
      7'b0000110, 7'b0001110, 7'b0010110: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input bit ok, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Offer one op with out_ready high, verify the registered outcome.
  task automatic run_op(input logic [6:0] f, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
    logic [31:0] er;
    bit es;
    bit ei;
    model(f, a, b, er, es, ei);
    @(negedge clk);
    in_valid = 1'b1; in_func = f; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, out_valid && out_result == er && out_sat == es && out_illegal == ei,
          {29'd0, out_valid, out_sat, out_illegal, out_result},
          {29'd0, 1'b1, es, ei, er});
  endtask

  localparam logic [6:0] FNS [7] = '{7'b0000010, 7'b0000011, 7'b0001010,
                                     7'b0001011, 7'b0000110, 7'b0001110, 7'b0010110};

  initial begin
    logic [31:0] er1;
    logic [31:0] er2;
    bit es1;
    bit es2;
    bit ei1;
    bit ei2;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", !out_valid && in_ready, {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;

    // Directed corners
    run_op(7'b0000010, 32'h0000_7fff, 32'h0000_0001, "R2 pos clamp");
    run_op(7'b0000010, 32'h8000_0000, 32'h8000_0000, "R2 neg clamp");
    run_op(7'b0000010, 32'hffff_fff0, 32'h0000_0005, "R2 R13 in range");
    run_op(7'b0000011, 32'h0000_0000, 32'h8000_0000, "R3 clamp");
    run_op(7'b0000011, 32'hffff_8000, 32'h0000_0001, "R3 below min");
    run_op(7'b0001010, 32'hffff_ffff, 32'h0000_0001, "R4 wide sat");
    run_op(7'b0001010, 32'h0000_0100, 32'h0000_0200, "R4 small");
    run_op(7'b0001010, 32'h0000_8000, 32'h0000_0000, "R4 sext bit15");
    run_op(7'b0001011, 32'h0000_0005, 32'h0000_0007, "R5 floor");
    run_op(7'b0001011, 32'h0000_0007, 32'h0000_0005, "R5 plain");
    run_op(7'b0000110, 32'h1234_8000, 32'h5678_8000, "R7 bb min");
    run_op(7'b0001110, 32'h0000_8000, 32'h8000_0000, "R7 bt min");
    run_op(7'b0010110, 32'h8000_0000, 32'h8000_0000, "R7 tt min");
    run_op(7'b0001110, 32'h0000_4000, 32'h4000_0000, "R6 bt select");
    run_op(7'b0010110, 32'h4000_ffff, 32'h2000_ffff, "R6 tt select");
    run_op(7'b0000110, 32'h0000_ffff, 32'h0000_0001, "R6 neg shift");
    run_op(7'b1111111, 32'h0000_7fff, 32'h0000_7fff, "R9 illegal");
    run_op(7'b0000000, 32'h1234_5678, 32'h1, "R1 R9 zero code");

    // R11 / R10: back-pressure
    model(7'b0001010, 32'h10, 32'h20, er1, es1, ei1);
    model(7'b0000011, 32'h0, 32'h1, er2, es2, ei2);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_func = 7'b0001010; in_a = 32'h10; in_b = 32'h20;
    @(negedge clk);
    in_func = 7'b0000011; in_a = 32'h0; in_b = 32'h1;
    check("R10 stalled ready", !in_ready && out_valid, {62'd0, in_ready, out_valid}, 64'd1);
    @(negedge clk);
    check("R11 hold", out_valid && out_result == er1 && out_sat == es1,
          {31'd0, out_sat, out_result}, {31'd0, es1, er1});
    out_ready = 1'b1;
    #1;
    check("R10 ready follows", in_ready, {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 release", out_valid && out_result == er2 && out_sat == es2,
          {31'd0, out_sat, out_result}, {31'd0, es2, er2});
    @(negedge clk);
    check("R10 drain", !out_valid && !out_sat, {62'd0, out_valid, out_sat}, 64'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [6:0]  f;
      logic [31:0] a;
      logic [31:0] b;
      int sel;
      sel = $urandom_range(0, 9);
      f = (sel < 7) ? FNS[sel] : 7'($urandom());
      a = $urandom();
      b = $urandom();
      if ($urandom_range(0, 2) == 0) begin
        a = {{16{a[15]}}, a[15:0]};
        b = {{16{b[15]}}, b[15:0]};
      end
      if ($urandom_range(0, 5) == 0) a = {a[31:16], 16'h8000};
      run_op(f, a, b, tag_of(f));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule